// File: doc/BRIEF.md
# Write Beat and Strobe Checker

This block is a passive monitor that sits beside an AXI write-address and write-data channel pair. It never drives either channel. For every write burst it counts the accepted data beats and compares the count against the burst's length field. For each beat it also works out which byte lanes that beat may legally use, from the burst's start address, transfer size, burst kind and beat index, and flags any strobe bit set outside them. A separate monitor watches the data channel's handshake rules: the payload must stay stable while a beat waits for ready, valid must not drop before the beat is taken, and valid must be low in the first cycle after reset.

Accepted write addresses are held in a small in-order queue whose depth is a parameter. Data may run ahead of its address. Beats that arrive while no address is queued are counted, and their total is kept in a single lead record. That record is reconciled against the length field of the next address that arrives. Every violation appears as a one-cycle pulse on its own error output, in the cycle after the clock edge that accepted the offending event.

Top module: `wbeat_checker`

## Requirements
- R1: While reset is high and in the cycle after it, every error output is low. Each error output is a registered pulse that is high in the cycle following the clock edge at which its cause was sampled.
- R2: `err_len_last` pulses when a beat with WLAST set is accepted while an address is queued and the zero-based beat index differs from that address's length field (length field = beats minus one).
- R3: `err_len_over` pulses when a beat without WLAST is accepted while an address is queued and the beat index is already greater than or equal to the length field.
- R4: Beats accepted with an empty queue are counted. When such a burst ends with WLAST, its beat count is kept. The next accepted address is compared with it instead of being queued, and `err_len_late` pulses if the count is not length+1. An address accepted in the same cycle as such a WLAST beat is compared directly, with the beat index against the length field.
- R5: For an INCR burst (burst code 01), beat 0 may use lanes from the start address up to the end of its size-aligned container. Beat n>0 uses the container at aligned start + n*2^size. Lanes are taken modulo the bus byte width. Any strobe bit outside these lanes pulses `err_strb`.
- R6: For a FIXED burst (code 00), every beat uses beat 0's lanes. For a WRAP burst (code 10), the beat address wraps within a region of (length+1)*2^size bytes that is aligned to that size.
- R7: Beats accepted while no address is queued are not strobe-checked.
- R8: `err_hold` pulses when a beat was pending (valid high, ready low) in the previous cycle, valid is still high, and data, strobe, last or user has changed.
- R9: `err_drop` pulses when a beat was pending in the previous cycle and valid is now low.
- R10: `err_wreset` pulses when write valid is high in the first cycle after reset is released.
- R11: An address accepted while the queue holds DEPTH entries and no entry is popped in that cycle is discarded, and `err_overflow` pulses.
- R12: A WLAST beat accepted with an empty queue, while a lead record is already waiting and no address arrives to resolve it, pulses `err_underflow`. The new count is discarded.
- R13: A queue entry is removed only when a WLAST beat is accepted while it is at the head. An address pushed into a full queue in the same cycle as such a pop is kept, and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | ADDR_W | Burst start address |
| aw_len | input | 8 | Burst length field (beats minus one) |
| aw_size | input | 3 | Log2 of bytes per beat |
| aw_burst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Last beat of burst |
| w_user | input | USER_W | User sideband |
| err_len_last | output | 1 | Last beat at wrong index |
| err_len_over | output | 1 | Non-last beat at or past the length field |
| err_len_late | output | 1 | Lead data count disagrees with a later address |
| err_strb | output | 1 | Strobe outside the beat's legal lanes |
| err_hold | output | 1 | Pending beat payload changed |
| err_drop | output | 1 | Valid dropped before handshake |
| err_wreset | output | 1 | Valid high in first cycle after reset |
| err_overflow | output | 1 | Address discarded because the queue was full |
| err_underflow | output | 1 | Second lead burst ended with no address to pair |

## Verification
Two events can land in the same cycle and must be resolved together. The first is a WLAST beat that arrives with the queue empty while the address handshake completes in that same cycle. The second is an address pushed into a full queue in the same cycle that a WLAST beat pops the head. Directed cases drive both handshakes in one cycle. The first case is judged by whether `err_len_late` follows the beat index against the length field, and by the queue staying empty afterwards. The second is judged by the absence of `err_overflow` and by a strobe error that only the kept entry can produce. Random bursts of all three kinds, with legal and corrupted strobes, are compared with a lane model in the bench.

// File: rtl/wchk_pkg.sv
package wchk_pkg;

    localparam int LEN_W = 8;
    localparam int SIZE_W = 3;
    localparam int IDX_W = LEN_W + 1;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_RSVD  = 2'b11
    } burst_kind_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [SIZE_W-1:0] size;
        burst_kind_e       kind;
    } burst_ctl_t;

    typedef struct packed {
        logic underflow;
        logic overflow;
        logic wreset;
        logic drop;
        logic hold;
        logic strb;
        logic len_late;
        logic len_over;
        logic len_last;
    } err_flags_t;

    function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
        return (v == {IDX_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/wchk_addr_queue.sv
module wchk_addr_queue
    import wchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  burst_ctl_t        push_ctl,
    input  logic              pop,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output burst_ctl_t        head_ctl,
    output logic              full,
    output logic              overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_mem [DEPTH];
    burst_ctl_t        ctl_mem  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              accept, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_valid = (count != '0);
    assign full       = (count == CNT_W'(DEPTH));
    assign pop_ok     = pop & head_valid;
    assign accept     = push & (~full | pop_ok);
    assign overflow   = push & full & ~pop_ok;
    assign head_addr  = addr_mem[rd_ptr];
    assign head_ctl   = ctl_mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            addr_mem[wr_ptr] <= push_addr;
            ctl_mem[wr_ptr]  <= push_ctl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok) rd_ptr <= ptr_next(rd_ptr);
            case ({accept, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R13: the data side only pops an entry that is present
    p_pop_has_head_r13: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid);

    // R11: a discarded address leaves the occupancy unchanged
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/wchk_lane_calc.sv
module wchk_lane_calc
    import wchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]   start_addr,
    input  burst_ctl_t          ctl,
    input  logic [IDX_W-1:0]    beat_idx,
    output logic [DATA_W/8-1:0] lane_mask
);
    localparam int NB = DATA_W / 8;

    logic [ADDR_W-1:0] bytes, aligned, step, region, region_base, wrap_off;
    logic [ADDR_W-1:0] beat_addr, beat_aligned;
    int                lo, hi;

    always_comb begin
        bytes        = ADDR_W'(1) << ctl.size;
        step         = ADDR_W'(beat_idx) << ctl.size;
        aligned      = start_addr & ~(bytes - 1'b1);
        region       = ADDR_W'({1'b0, ctl.len} + 9'd1) << ctl.size;
        region_base  = start_addr & ~(region - 1'b1);
        wrap_off     = ((aligned - region_base) + step) & (region - 1'b1);
        case (ctl.kind)
            BK_FIXED: beat_addr = start_addr;
            BK_WRAP:  beat_addr = (beat_idx == '0) ? start_addr : region_base + wrap_off;
            default:  beat_addr = (beat_idx == '0) ? start_addr : aligned + step;
        endcase
        beat_aligned = beat_addr & ~(bytes - 1'b1);
        lo = int'(beat_addr % ADDR_W'(NB));
        hi = int'(beat_aligned % ADDR_W'(NB)) + int'(bytes) - 1;
    end

    for (genvar j = 0; j < NB; j++) begin : g_lane
        assign lane_mask[j] = (j >= lo) && (j <= hi);
    end

endmodule

// File: rtl/wchk_hold_mon.sv
module wchk_hold_mon #(
    parameter int DATA_W = 32,
    parameter int USER_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                w_valid,
    input  logic                w_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic [USER_W-1:0]   w_user,
    output logic                hold_err,
    output logic                drop_err,
    output logic                reset_err
);
    localparam int NB = DATA_W / 8;

    logic              waiting_q, first_q;
    logic [DATA_W-1:0] data_q;
    logic [NB-1:0]     strb_q;
    logic              last_q;
    logic [USER_W-1:0] user_q;
    logic              changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting_q <= 1'b0;
            first_q   <= 1'b1;
        end else begin
            waiting_q <= w_valid & ~w_ready;
            first_q   <= 1'b0;
        end
        data_q <= w_data;
        strb_q <= w_strb;
        last_q <= w_last;
        user_q <= w_user;
    end

    assign changed   = (data_q != w_data) | (strb_q != w_strb) |
                       (last_q != w_last) | (user_q != w_user);
    assign hold_err  = waiting_q & w_valid & changed;
    assign drop_err  = waiting_q & ~w_valid;
    assign reset_err = first_q & w_valid & ~rst;

endmodule

// File: rtl/wbeat_checker.sv
module wbeat_checker
    import wchk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int USER_W = 4,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                aw_valid,
    input  logic                aw_ready,
    input  logic [ADDR_W-1:0]   aw_addr,
    input  logic [7:0]          aw_len,
    input  logic [2:0]          aw_size,
    input  logic [1:0]          aw_burst,
    input  logic                w_valid,
    input  logic                w_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    input  logic [USER_W-1:0]   w_user,
    output logic                err_len_last,
    output logic                err_len_over,
    output logic                err_len_late,
    output logic                err_strb,
    output logic                err_hold,
    output logic                err_drop,
    output logic                err_wreset,
    output logic                err_overflow,
    output logic                err_underflow
);
    localparam int NB = DATA_W / 8;

    logic              aw_hs, w_hs;
    logic              head_valid, q_full, q_ovf;
    logic [ADDR_W-1:0] head_addr;
    burst_ctl_t        head_ctl, aw_ctl;
    logic [NB-1:0]     lane_mask;
    logic [IDX_W-1:0]  beat_idx_q;
    logic              lead_q;
    logic [IDX_W-1:0]  lead_beats_q;
    logic              lead_last, aw_to_lead_rec, aw_to_lead_now, push, pop;
    logic              hold_err, drop_err, reset_err;
    err_flags_t        flags_d, flags_q;

    assign aw_hs   = aw_valid & aw_ready;
    assign w_hs    = w_valid & w_ready;
    assign aw_ctl  = '{len: aw_len, size: aw_size, kind: burst_kind_e'(aw_burst)};

    assign lead_last      = w_hs & w_last & ~head_valid;
    assign aw_to_lead_rec = aw_hs & lead_q;
    assign aw_to_lead_now = aw_hs & ~lead_q & lead_last;
    assign push           = aw_hs & ~aw_to_lead_rec & ~aw_to_lead_now;
    assign pop            = w_hs & w_last & head_valid;

    wchk_addr_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_addr  (aw_addr),
        .push_ctl   (aw_ctl),
        .pop        (pop),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .head_ctl   (head_ctl),
        .full       (q_full),
        .overflow   (q_ovf)
    );

    wchk_lane_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
        .start_addr (head_addr),
        .ctl        (head_ctl),
        .beat_idx   (beat_idx_q),
        .lane_mask  (lane_mask)
    );

    wchk_hold_mon #(.DATA_W(DATA_W), .USER_W(USER_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .w_valid   (w_valid),
        .w_ready   (w_ready),
        .w_data    (w_data),
        .w_strb    (w_strb),
        .w_last    (w_last),
        .w_user    (w_user),
        .hold_err  (hold_err),
        .drop_err  (drop_err),
        .reset_err (reset_err)
    );

    always_comb begin
        flags_d           = '0;
        flags_d.len_last  = w_hs & head_valid & w_last &
                            (beat_idx_q != {1'b0, head_ctl.len});
        flags_d.len_over  = w_hs & head_valid & ~w_last &
                            (beat_idx_q >= {1'b0, head_ctl.len});
        flags_d.len_late  = (aw_to_lead_rec & (lead_beats_q != ({1'b0, aw_len} + 9'd1))) |
                            (aw_to_lead_now & (beat_idx_q != {1'b0, aw_len}));
        flags_d.strb      = w_hs & head_valid & (|(w_strb & ~lane_mask));
        flags_d.hold      = hold_err;
        flags_d.drop      = drop_err;
        flags_d.wreset    = reset_err;
        flags_d.overflow  = q_ovf;
        flags_d.underflow = lead_last & ~aw_to_lead_now & lead_q & ~aw_to_lead_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_idx_q   <= '0;
            lead_q       <= 1'b0;
            lead_beats_q <= '0;
            flags_q      <= '0;
        end else begin
            flags_q <= flags_d;
            if (w_hs) beat_idx_q <= w_last ? '0 : sat_inc(beat_idx_q);
            if (lead_last && !aw_to_lead_now) begin
                if (!lead_q || aw_to_lead_rec) begin
                    lead_q       <= 1'b1;
                    lead_beats_q <= sat_inc(beat_idx_q);
                end
            end else if (aw_to_lead_rec) begin
                lead_q <= 1'b0;
            end
        end
    end

    assign err_len_last  = flags_q.len_last;
    assign err_len_over  = flags_q.len_over;
    assign err_len_late  = flags_q.len_late;
    assign err_strb      = flags_q.strb;
    assign err_hold      = flags_q.hold;
    assign err_drop      = flags_q.drop;
    assign err_wreset    = flags_q.wreset;
    assign err_overflow  = flags_q.overflow;
    assign err_underflow = flags_q.underflow;

    p_len_last_cause_r2: assert property (@(posedge clk) disable iff (rst)
        err_len_last |-> $past(w_valid && w_ready && w_last));

    p_len_over_cause_r3: assert property (@(posedge clk) disable iff (rst)
        err_len_over |-> $past(w_valid && w_ready && !w_last));

    p_strb_cause_r5: assert property (@(posedge clk) disable iff (rst)
        err_strb |-> $past(w_valid && w_ready));

    p_drop_cause_r9: assert property (@(posedge clk) disable iff (rst)
        err_drop |-> !$past(w_valid));

    p_wreset_cause_r10: assert property (@(posedge clk) disable iff (rst)
        err_wreset |-> $past(w_valid));

    p_underflow_cause_r12: assert property (@(posedge clk) disable iff (rst)
        err_underflow |-> $past(w_valid && w_ready && w_last));

    p_overflow_cause_r11: assert property (@(posedge clk) disable iff (rst)
        err_overflow |-> $past(aw_valid && aw_ready));

endmodule

// File: tb/test_wbeat_checker.sv
module test_wbeat_checker;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int USER_W = 4;
    localparam int DEPTH  = 2;
    localparam int NB     = DATA_W / 8;

    localparam logic [8:0] F_LAST  = 9'h001;
    localparam logic [8:0] F_OVER  = 9'h002;
    localparam logic [8:0] F_LATE  = 9'h004;
    localparam logic [8:0] F_STRB  = 9'h008;
    localparam logic [8:0] F_HOLD  = 9'h010;
    localparam logic [8:0] F_DROP  = 9'h020;
    localparam logic [8:0] F_WRST  = 9'h040;
    localparam logic [8:0] F_OVF   = 9'h080;
    localparam logic [8:0] F_UNF   = 9'h100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic aw_valid = 1'b0, aw_ready = 1'b0;
    logic [ADDR_W-1:0] aw_addr = '0;
    logic [7:0] aw_len = '0;
    logic [2:0] aw_size = '0;
    logic [1:0] aw_burst = '0;
    logic w_valid = 1'b0, w_ready = 1'b0;
    logic [DATA_W-1:0] w_data = '0;
    logic [NB-1:0] w_strb = '0;
    logic w_last = 1'b0;
    logic [USER_W-1:0] w_user = '0;
    logic err_len_last, err_len_over, err_len_late, err_strb, err_hold;
    logic err_drop, err_wreset, err_overflow, err_underflow;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wbeat_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_W(USER_W), .DEPTH(DEPTH)) i_wbeat_checker (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
        .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .w_last(w_last), .w_user(w_user),
        .err_len_last(err_len_last), .err_len_over(err_len_over), .err_len_late(err_len_late),
        .err_strb(err_strb), .err_hold(err_hold), .err_drop(err_drop),
        .err_wreset(err_wreset), .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    function automatic string flag_req(input int b);
        case (b)
            0: return "R2 len_last";
            1: return "R3 len_over";
            2: return "R4 len_late";
            3: return "R5/R6 strb";
            4: return "R8 hold";
            5: return "R9 drop";
            6: return "R10 wreset";
            7: return "R11 overflow";
            default: return "R12 underflow";
        endcase
    endfunction

    // Lane model: beat address per burst kind, then lanes modulo bus width
    function automatic logic [NB-1:0] bench_mask(input int addr, input int len,
                                                 input int size, input int kind, input int n);
        int bytes, aligned, a, total, lowb, lo, hi;
        logic [NB-1:0] m;
        bytes   = 1 << size;
        aligned = (addr / bytes) * bytes;
        if (kind == 0 || n == 0) a = addr;
        else a = aligned + n * bytes;
        if (kind == 2 && n != 0) begin
            total = bytes * (len + 1);
            lowb  = (addr / total) * total;
            if (a >= lowb + total) a = a - total;
        end
        lo = a % NB;
        hi = ((a / bytes) * bytes) % NB + bytes - 1;
        for (int j = 0; j < NB; j++) m[j] = (j >= lo) && (j <= hi);
        return m;
    endfunction

    task automatic step(input logic [8:0] exp, input string ctx);
        logic [8:0] act;
        @(posedge clk);
        #1;
        act = {err_underflow, err_overflow, err_wreset, err_drop, err_hold,
               err_strb, err_len_late, err_len_over, err_len_last};
        for (int b = 0; b < 9; b++) begin
            n_chk++;
            if (act[b] !== exp[b]) begin
                n_err++;
                $display("FAIL %s [%s] actual=%0b expected=%0b", ctx, flag_req(b), act[b], exp[b]);
            end
        end
        aw_valid = 1'b0;
        w_valid  = 1'b0;
    endtask

    task automatic set_aw(input int addr, input int len, input int size, input int kind);
        aw_valid = 1'b1; aw_ready = 1'b1;
        aw_addr = ADDR_W'(addr); aw_len = 8'(len); aw_size = 3'(size); aw_burst = 2'(kind);
    endtask

    task automatic set_w(input logic [NB-1:0] strb, input logic last, input logic ready);
        w_valid = 1'b1; w_ready = ready; w_strb = strb; w_last = last;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: flags low throughout reset
        step(9'h0, "R1 reset");
        step(9'h0, "R1 reset");
        // R10: valid in first cycle after release; it is a lone lead WLAST (R4)
        rst = 1'b0;
        set_w(4'hF, 1'b1, 1'b1);
        step(F_WRST, "R10 first cycle");
        set_aw(0, 0, 2, 1);
        step(9'h0, "R4 late addr matches one lead beat");

        // R4: three lead beats, address says two
        set_w(4'hF, 1'b0, 1'b1); step(9'h0, "R4 lead beat");
        set_w(4'hF, 1'b0, 1'b1); step(9'h0, "R4 lead beat");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R4 lead last");
        set_aw(0, 1, 2, 1);      step(F_LATE, "R4 late addr mismatch");

        // R4: address in the same cycle as the lead WLAST
        set_w(4'hF, 1'b0, 1'b1); step(9'h0, "R4 lead beat");
        set_w(4'hF, 1'b1, 1'b1); set_aw(0, 1, 2, 1); step(9'h0, "R4 same-cycle match");
        set_w(4'hF, 1'b0, 1'b1); step(9'h0, "R4 lead beat");
        set_w(4'hF, 1'b1, 1'b1); set_aw(0, 3, 2, 1); step(F_LATE, "R4 same-cycle mismatch");
        // queue must be empty: a lone lead last with bad strobe gives no strb flag (R7)
        set_w(4'h1, 1'b1, 1'b1); step(9'h0, "R7 lead beat unchecked");
        set_aw(3, 0, 0, 1);      step(9'h0, "R4 resolve");

        // R5: INCR unaligned, size 1: masks 1100, 0011, 1100
        set_aw('h102, 2, 1, 1);   step(9'h0, "R5 addr");
        set_w(4'b1100, 1'b0, 1'b1); step(9'h0, "R5 beat0");
        set_w(4'b0011, 1'b0, 1'b1); step(9'h0, "R5 beat1");
        set_w(4'b0011, 1'b1, 1'b1); step(F_STRB, "R5 beat2 wrong lanes");
        // R5: size 2 from address 1 -> beat0 lanes 1..3
        set_aw('h101, 0, 2, 1);   step(9'h0, "R5 addr");
        set_w(4'b1111, 1'b1, 1'b1); step(F_STRB, "R5 unaligned beat0 lane0");
        // R6: FIXED at lane 3, size 0
        set_aw('h3, 2, 0, 0);     step(9'h0, "R6 fixed addr");
        set_w(4'b1000, 1'b0, 1'b1); step(9'h0, "R6 fixed beat0");
        set_w(4'b1000, 1'b0, 1'b1); step(9'h0, "R6 fixed beat1");
        set_w(4'b0001, 1'b1, 1'b1); step(F_STRB, "R6 fixed beat2 moved");
        // R6: WRAP size 0 len 3 from 6: lanes 2,3,0,1
        set_aw('h6, 3, 0, 2);     step(9'h0, "R6 wrap addr");
        set_w(4'b0100, 1'b0, 1'b1); step(9'h0, "R6 wrap beat0");
        set_w(4'b1000, 1'b0, 1'b1); step(9'h0, "R6 wrap beat1");
        set_w(4'b0001, 1'b0, 1'b1); step(9'h0, "R6 wrap beat2 wrapped");
        set_w(4'b0100, 1'b1, 1'b1); step(F_STRB, "R6 wrap beat3 expects lane1");

        // R2 / R3
        set_aw(0, 1, 2, 1);       step(9'h0, "R2 addr");
        set_w(4'hF, 1'b1, 1'b1);  step(F_LAST, "R2 early last");
        set_aw(0, 0, 2, 1);       step(9'h0, "R3 addr");
        set_w(4'hF, 1'b0, 1'b1);  step(F_OVER, "R3 missing last");
        set_w(4'hF, 1'b1, 1'b1);  step(F_LAST, "R2 late last");

        // R12: two lead bursts with no address
        set_w(4'hF, 1'b1, 1'b1);  step(9'h0, "R12 first lead");
        set_w(4'hF, 1'b0, 1'b1);  step(9'h0, "R12 second lead beat");
        set_w(4'hF, 1'b1, 1'b1);  step(F_UNF, "R12 second lead last");
        set_aw(0, 0, 2, 1);       step(9'h0, "R12 kept first record");

        // R11: third address dropped with DEPTH=2
        set_aw(0, 0, 2, 1); step(9'h0, "R11 push A");
        set_aw(0, 0, 2, 1); step(9'h0, "R11 push B");
        set_aw(0, 0, 2, 1); step(F_OVF, "R11 push C full");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R13 pop A");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R13 pop B");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R11 C absent, lead");
        set_aw(0, 1, 2, 1);      step(F_LATE, "R11 C was dropped");
        // R13: push into full queue while popping
        set_aw(0, 0, 2, 1); step(9'h0, "R13 push D");
        set_aw(0, 0, 2, 1); step(9'h0, "R13 push E");
        set_aw('h1, 0, 0, 1); set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R13 push F with pop D");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R13 pop E");
        set_w(4'b0001, 1'b1, 1'b1); step(F_STRB, "R13 F kept, lane1 only");

        // R8 / R9
        set_aw(0, 0, 2, 1); step(9'h0, "R8 addr");
        w_data = 32'h1111; set_w(4'hF, 1'b1, 1'b0); step(9'h0, "R8 wait");
        w_data = 32'h2222; set_w(4'hF, 1'b1, 1'b0); step(F_HOLD, "R8 data changed");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R8 accept");
        set_aw(0, 0, 2, 1); step(9'h0, "R9 addr");
        set_w(4'hF, 1'b1, 1'b0); step(9'h0, "R9 wait");
        step(F_DROP, "R9 valid dropped");
        set_w(4'hF, 1'b1, 1'b1); step(9'h0, "R9 accept");

        // Random bursts: R5/R6 strobe lanes and R2/R3 counts
        for (int t = 0; t < 150; t++) begin
            int kind, size, len, addr;
            kind = int'($urandom % 3);
            size = int'($urandom % 3);
            if (kind == 2) len = (2 << ($urandom % 4)) - 1;
            else len = int'($urandom % 16);
            addr = int'($urandom % 4096);
            if (kind == 2) addr = addr & ~((1 << size) - 1);
            set_aw(addr, len, size, kind); step(9'h0, "R5 random addr");
            for (int n = 0; n <= len; n++) begin
                logic [NB-1:0] m, s;
                m = bench_mask(addr, len, size, kind, n);
                s = NB'($urandom) & m;
                if ($urandom % 4 == 0) s = s | (NB'($urandom) & ~m);
                w_data = $urandom;
                set_w(s, n == len, 1'b1);
                step((|(s & ~m)) ? F_STRB : 9'h0, "R5/R6 random beat");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule